// File: doc/BRIEF.md
# Two-Port GPIO Bridge with NAND and Serial-Sensor Pin Decoding

This block is a small memory-mapped general-purpose I/O unit with two ports, named A and D. Each port has an output-data register, an output-enable register and an input-data view, all on a simple word-oriented register bus. The bus uses a byte address; the word index is that address divided by four. The window is 0x5C bytes long. Any word in the window without special decoding works as plain storage and reads back its last written value.

Some pins carry peripheral lines. On port A, three output bits drive the address-latch, command-latch and chip-enable lines of a NAND flash. The flash ready line is merged into port A input reads. On port D, bit 1 is the clock of a bit-banged serial temperature sensor and bit 4 is the data sent to it. Every write that changes the clock bit produces a one-cycle edge strobe that carries the new level and the data bit. The sensor's serial output is merged into port D input reads. The NAND protocol and the sensor logic sit outside this block.

Top module: `gpio_pin_bridge`

## Requirements
- R1: After reset every register reads as zero, all output enables are zero and the three NAND control outputs are low. The input-data words then show only the live peripheral bits.
- R2: In the window, words 0x00, 0x02, 0x10 and 0x12 and every other word except 0x01 and 0x11 return on `regRdata` the value last written to them. The read is combinational on `regAddr`.
- R3: A read of word 0x01 returns port A output data AND port A output enable, with `nandRdy` ORed into bit 7.
- R4: A read of word 0x11 returns port D output data AND port D output enable, with `snsDout` ORed into bit 4.
- R5: After a write to word 0x00, from the next cycle `nandAle` equals written bit 6, `nandCle` equals bit 5 and `nandCe` equals bit 4.
- R6: A write to word 0x10 whose bit 1 differs from the stored bit 1 raises `snsClkStrobe` for that one cycle. In the same cycle `snsClkLevel` equals written bit 1 and `snsData` equals written bit 4.
- R7: `snsClkStrobe` stays low when bit 1 does not change, on writes to any other word, and when no write occurs.
- R8: Byte addresses at or above 0x5C read as zero, and writes to them change no register. The two low address bits never select anything.
- R9: A write to word 0x01 or 0x11 leaves the value read from that word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Write strobe for the register bus |
| regAddr | input | 7 | Byte address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| nandRdy | input | 1 | NAND ready line |
| snsDout | input | 1 | Serial output of the temperature sensor |
| nandAle | output | 1 | NAND address latch enable |
| nandCle | output | 1 | NAND command latch enable |
| nandCe | output | 1 | NAND chip enable |
| snsClkStrobe | output | 1 | One-cycle sensor clock edge event |
| snsClkLevel | output | 1 | New sensor clock level on an edge |
| snsData | output | 1 | Data bit sent with the edge |
| portAOut | output | 32 | Port A output data |
| portAOe | output | 32 | Port A output enable |
| portDOut | output | 32 | Port D output data |
| portDOe | output | 32 | Port D output enable |

## Verification
The hardest case to reach is a port D write in which the clock bit stays the same while other bits change. The strobe must stay low even though the data bit and the other bits move. The random stimulus favours the port D data word, and most of its values are drawn near the stored value with a random choice of whether bit 1 flips. This exercises both the edge and no-edge cases many times at each clock level. Directed writes beyond the window and to the two input words then show through later reads that nothing was stored.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int WORD_DOUT_A = 'h00;
  localparam int WORD_DIN_A  = 'h01;
  localparam int WORD_OE_A   = 'h02;
  localparam int WORD_DOUT_D = 'h10;
  localparam int WORD_DIN_D  = 'h11;
  localparam int WORD_OE_D   = 'h12;

  localparam int BIT_NAND_RDY = 7;
  localparam int BIT_NAND_ALE = 6;
  localparam int BIT_NAND_CLE = 5;
  localparam int BIT_NAND_CE  = 4;
  localparam int BIT_SNS_CLK  = 1;
  localparam int BIT_SNS_DAT  = 4;

  typedef struct packed {
    logic store;     // write lands in the register file
    logic selDinA;   // read of port A input view
    logic selDinD;   // read of port D input view
    logic selVoid;   // address outside window
    logic clkEdge;   // sensor clock changes on this write
  } gpbStrobes_t;
endpackage

// File: rtl/gpb_ctrl.sv
module gpb_ctrl
  import gpb_pkg::*;
#(
  parameter int ADDR_W       = 7,
  parameter int WINDOW_BYTES = 'h5C,
  localparam int IDX_W       = ADDR_W - 2
) (
  input  logic             regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic             newClkBit,
  input  logic             curClkBit,
  output logic [IDX_W-1:0] wordIdx,
  output gpbStrobes_t      strb
);
  logic inWindow;

  assign wordIdx  = regAddr[ADDR_W-1:2];
  assign inWindow = (int'(regAddr) < WINDOW_BYTES);

  always_comb begin
    strb         = '0;
    strb.selVoid = !inWindow;
    strb.store   = regWe && inWindow;
    strb.selDinA = inWindow && (int'(wordIdx) == WORD_DIN_A);
    strb.selDinD = inWindow && (int'(wordIdx) == WORD_DIN_D);
    strb.clkEdge = regWe && inWindow && (int'(wordIdx) == WORD_DOUT_D)
                   && (newClkBit != curClkBit);
  end
endmodule

// File: rtl/gpb_datapath.sv
module gpb_datapath
  import gpb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5,
  parameter int WORDS  = 23
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpbStrobes_t       strb,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              nandRdy,
  input  logic              snsDout,
  output logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] portAOut,
  output logic [DATA_W-1:0] portAOe,
  output logic [DATA_W-1:0] portDOut,
  output logic [DATA_W-1:0] portDOe
);
  logic [DATA_W-1:0] regFile [WORDS];
  logic [DATA_W-1:0] dinA, dinD;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regFile[w] <= '0;
      else if (strb.store && (int'(wordIdx) == w))
        regFile[w] <= regWdata;
    end
  end

  assign portAOut = regFile[WORD_DOUT_A];
  assign portAOe  = regFile[WORD_OE_A];
  assign portDOut = regFile[WORD_DOUT_D];
  assign portDOe  = regFile[WORD_OE_D];

  always_comb begin
    dinA = portAOut & portAOe;
    dinA[BIT_NAND_RDY] = dinA[BIT_NAND_RDY] | nandRdy;
    dinD = portDOut & portDOe;
    dinD[BIT_SNS_DAT] = dinD[BIT_SNS_DAT] | snsDout;
  end

  always_comb begin
    if (strb.selVoid)      regRdata = '0;
    else if (strb.selDinA) regRdata = dinA;
    else if (strb.selDinD) regRdata = dinD;
    else                   regRdata = regFile[wordIdx];
  end
endmodule

// File: rtl/gpio_pin_bridge.sv
module gpio_pin_bridge
  import gpb_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 7,
  parameter int WINDOW_BYTES = 'h5C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              nandRdy,
  input  logic              snsDout,
  output logic              nandAle,
  output logic              nandCle,
  output logic              nandCe,
  output logic              snsClkStrobe,
  output logic              snsClkLevel,
  output logic              snsData,
  output logic [DATA_W-1:0] portAOut,
  output logic [DATA_W-1:0] portAOe,
  output logic [DATA_W-1:0] portDOut,
  output logic [DATA_W-1:0] portDOe
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int WORDS = WINDOW_BYTES / 4;

  gpbStrobes_t      strb;
  logic [IDX_W-1:0] wordIdx;

  gpb_ctrl #(.ADDR_W(ADDR_W), .WINDOW_BYTES(WINDOW_BYTES)) u_ctrl (
    .regWe    (regWe),
    .regAddr  (regAddr),
    .newClkBit(regWdata[BIT_SNS_CLK]),
    .curClkBit(portDOut[BIT_SNS_CLK]),
    .wordIdx  (wordIdx),
    .strb     (strb)
  );

  gpb_datapath #(.DATA_W(DATA_W), .IDX_W(IDX_W), .WORDS(WORDS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wordIdx (wordIdx),
    .regWdata(regWdata),
    .nandRdy (nandRdy),
    .snsDout (snsDout),
    .regRdata(regRdata),
    .portAOut(portAOut),
    .portAOe (portAOe),
    .portDOut(portDOut),
    .portDOe (portDOe)
  );

  assign nandAle      = portAOut[BIT_NAND_ALE];
  assign nandCle      = portAOut[BIT_NAND_CLE];
  assign nandCe       = portAOut[BIT_NAND_CE];
  assign snsClkStrobe = strb.clkEdge;
  assign snsClkLevel  = regWdata[BIT_SNS_CLK];
  assign snsData      = regWdata[BIT_SNS_DAT];
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker
  import gpb_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 7,
  parameter int WINDOW_BYTES = 'h5C
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              nandRdy,
  input logic              snsDout,
  input logic              nandAle,
  input logic              nandCle,
  input logic              nandCe,
  input logic              snsClkStrobe,
  input logic              snsClkLevel,
  input logic              snsData,
  input logic [DATA_W-1:0] portAOut,
  input logic [DATA_W-1:0] portAOe,
  input logic [DATA_W-1:0] portDOut,
  input logic [DATA_W-1:0] portDOe
);
  logic inWin;
  logic [ADDR_W-3:0] idx;
  assign inWin = (int'(regAddr) < WINDOW_BYTES);
  assign idx   = regAddr[ADDR_W-1:2];

  // R6: an edge strobe always moves the stored clock bit to the strobed level
  a_r6_edge_moves_clock: assert property (@(posedge clk) disable iff (!rstN)
    snsClkStrobe |=> portDOut[BIT_SNS_CLK] == $past(snsClkLevel));

  // R6: an edge strobe is only issued against a differing stored level
  a_r6_edge_differs: assert property (@(posedge clk) disable iff (!rstN)
    snsClkStrobe |-> portDOut[BIT_SNS_CLK] != snsClkLevel);

  // R7: no strobe without a bus write
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |-> !snsClkStrobe);

  // R5: NAND latch lines follow a port A data write
  a_r5_nand_lines: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && inWin && int'(idx) == WORD_DOUT_A) |=>
      {nandAle, nandCle, nandCe} == $past({regWdata[BIT_NAND_ALE],
        regWdata[BIT_NAND_CLE], regWdata[BIT_NAND_CE]}));

  // R3: ready line visible in port A input view
  a_r3_ready_merge: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && int'(idx) == WORD_DIN_A && nandRdy) |-> regRdata[BIT_NAND_RDY]);

  // R8: outside the window reads are zero
  a_r8_void_zero: assert property (@(posedge clk) disable iff (!rstN)
    !inWin |-> regRdata == '0);

  // R8: a write outside the window leaves the port registers alone
  a_r8_void_nowrite: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !inWin) |=> $stable(portAOut) && $stable(portDOut)
      && $stable(portAOe) && $stable(portDOe));
endmodule

bind gpio_pin_bridge gpb_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WINDOW_BYTES(WINDOW_BYTES)
) chk (.*);

// File: tb/tb_gpio_pin_bridge.sv
`timescale 1ns/1ps
module tb_gpio_pin_bridge;
  localparam int DW = 32;
  localparam int AW = 7;
  localparam int WIN = 'h5C;
  localparam int NW = WIN / 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWdata = '0;
  logic [DW-1:0] regRdata;
  logic nandRdy = 1'b0, snsDout = 1'b0;
  logic nandAle, nandCle, nandCe, snsClkStrobe, snsClkLevel, snsData;
  logic [DW-1:0] portAOut, portAOe, portDOut, portDOe;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] model [NW];

  always #4 clk = ~clk;

  gpio_pin_bridge dut (.*);

  function automatic logic [DW-1:0] expRead(int word, logic rdy, logic sdo);
    logic [DW-1:0] v;
    if (word >= NW) return '0;
    if (word == 'h01) begin
      v = model[0] & model[2];
      v[7] = v[7] | rdy;
      return v;
    end
    if (word == 'h11) begin
      v = model['h10] & model['h12];
      v[4] = v[4] | sdo;
      return v;
    end
    return model[word];
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, check before posedge, update model after
  task automatic step(string req, logic we, logic [AW-1:0] a, logic [DW-1:0] d,
                      logic rdy, logic sdo);
    int word;
    logic expEdge;
    word = int'(a) / 4;
    @(negedge clk);
    regWe = we; regAddr = a; regWdata = d; nandRdy = rdy; snsDout = sdo;
    #2;
    check({req, " read"}, regRdata, expRead(word, rdy, sdo));
    expEdge = we && (int'(a) < WIN) && (word == 'h10) && (d[1] != model['h10][1]);
    check("R6/R7 strobe", {31'd0, snsClkStrobe}, {31'd0, expEdge});
    if (expEdge)
      check("R6 level/data", {30'd0, snsClkLevel, snsData}, {30'd0, d[1], d[4]});
    check("R5 nand lines", {29'd0, nandAle, nandCle, nandCe},
          {29'd0, model[0][6], model[0][5], model[0][4]});
    @(posedge clk); #1;
    if (we && int'(a) < WIN) model[word] = d;
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    int pick;
    int word;
    logic [DW-1:0] d;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < NW; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    check("R1 portAOe", portAOe, '0);
    check("R1 portDOe", portDOe, '0);
    step("R1", 1'b0, 7'h00, '0, 1'b0, 1'b0);
    step("R1", 1'b0, 7'h01, '0, 1'b0, 1'b0);
    step("R1", 1'b0, 7'h44, '0, 1'b0, 1'b1);
    step("R1", 1'b0, 7'h48, '0, 1'b0, 1'b0);

    // R3 / R5 directed
    step("R5", 1'b1, 7'h00, 32'h0000_00F0, 1'b0, 1'b0);
    step("R2", 1'b1, 7'h08, 32'h0000_0050, 1'b1, 1'b0);
    step("R3", 1'b0, 7'h04, '0, 1'b1, 1'b0);
    step("R3", 1'b0, 7'h07, '0, 1'b0, 1'b0);
    // R9: writes to input views do not change them
    step("R9", 1'b1, 7'h04, 32'hFFFF_FFFF, 1'b0, 1'b0);
    step("R9", 1'b0, 7'h04, '0, 1'b0, 1'b0);
    step("R9", 1'b1, 7'h44, 32'hFFFF_FFFF, 1'b0, 1'b0);
    step("R9", 1'b0, 7'h44, '0, 1'b0, 1'b1);
    // R6 / R7 directed: edge up, same level, edge down
    step("R6", 1'b1, 7'h48, 32'h0000_0012, 1'b0, 1'b0);
    step("R6", 1'b1, 7'h40, 32'h0000_0012, 1'b0, 1'b0);
    step("R7", 1'b1, 7'h40, 32'h0000_00F2, 1'b0, 1'b0);
    step("R6", 1'b1, 7'h41, 32'h0000_0010, 1'b0, 1'b0);
    step("R4", 1'b0, 7'h44, '0, 1'b0, 1'b1);
    // R8: outside the window
    step("R8", 1'b1, 7'h5C, 32'hDEAD_BEEF, 1'b0, 1'b0);
    step("R8", 1'b0, 7'h5C, '0, 1'b0, 1'b0);
    step("R8", 1'b1, 7'h7F, 32'h1234_5678, 1'b1, 1'b1);
    step("R8", 1'b0, 7'h58, '0, 1'b0, 1'b0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      pick = int'($urandom_range(0, 9));
      case (pick)
        0, 1, 2: word = 'h10;
        3: word = 'h00;
        4: word = 'h01;
        5: word = 'h11;
        6: word = ($urandom_range(0, 1) != 0) ? 'h02 : 'h12;
        default: word = int'($urandom_range(0, 31));
      endcase
      d = $urandom;
      if (word == 'h10 && $urandom_range(0, 3) != 0) begin
        d = model['h10] ^ ($urandom & 32'hFFFF_FFFD);
        d[1] = model['h10][1] ^ 1'($urandom_range(0, 1));
      end
      step("R2/R3/R4/R6/R7/R8", 1'($urandom_range(0, 1)),
           AW'(word * 4 + int'($urandom_range(0, 3))), d,
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    @(negedge clk);
    regWe = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule